// File: doc/BRIEF.md
# Byte-Lane Word Memory with Pin-Mode Decode

This block is a synthesizable device-side model of an asynchronous word-wide memory. The active-low control pins are chip select, write strobe, read strobe and one select per byte lane. A clock samples them, and the sampled values are decoded into one of four operating modes: deselected, outputs quiet, read and write. Each byte lane has its own registered data output and its own registered drive-enable. A top level can map these onto bidirectional pins.

Writes update only the lanes whose select is low. A write strobe always wins over the read strobe. A synchronous supply-low flag blocks every write. After that flag clears, or after reset, writes stay blocked for a programmable number of cycles. The storage array has no reset, so its contents survive a reset of the control logic, as a nonvolatile part would behave.

Top module: `bytemem_core`

## Requirements
- R1: While chip select `ce_n` is high, both `dout_en` bits are 0, `dout` is 0, and no lane is written whatever the other pins do.
- R2: With `ce_n` low and `we_n` high, `dout_en` is 0 if `oe_n` is high or if every bit of `bs_n` is high.
- R3: With `ce_n` and `oe_n` low and `we_n` high, `dout_en[i]` is 1 exactly when `bs_n[i]` is 0, where bit 0 is the lower byte `dout[7:0]` and bit 1 is the upper byte `dout[15:8]`. An enabled lane carries the stored byte at `addr`, and a disabled lane reads 0.
- R4: With `ce_n` and `we_n` low, each lane with `bs_n[i]` low stores its byte of `din` at `addr`, and lanes whose select is high keep their old contents, whatever the level of `oe_n`.
- R5: While `we_n` is sampled low with `ce_n` low, `dout_en` stays 0 even when `oe_n` is low.
- R6: While `supply_low` is high, no write changes the array.
- R7: Writes remain blocked for `RECOVER_CYC` cycles after `supply_low` falls and after reset is released.
- R8: Array contents are unchanged by asserting and releasing `rst`.
- R9: During and right after reset, `dout_en` and `dout` are 0.
- R10: `dout` and `dout_en` reflect pin values on the second rising clock edge after those values are applied, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of control state |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read output strobe, active low |
| bs_n | input | LANES | Per-lane byte select, active low; bit 0 is the lower byte |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| supply_low | input | 1 | Supply-low flag; blocks writes |
| dout | output | LANES*LANE_W | Registered read data, 0 on lanes that do not drive |
| dout_en | output | LANES | Registered per-lane drive enable |

## Verification
Pins pass through one sampling register. Mode decode is combinational, and both the output registers and the array write act on the next edge, so each result is due on the second rising edge after the stimulus. Every scenario task applies pins on a falling edge, waits two rising edges, and samples on the following falling edge. The latency scenario also samples after the first edge to show that nothing has changed yet. The write-inhibit scenarios are judged by a read issued after the window in question, because a blocked write is only visible through the data.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

    typedef enum logic [1:0] {
        MD_DESEL = 2'd0,
        MD_QUIET = 2'd1,
        MD_READ  = 2'd2,
        MD_WRITE = 2'd3
    } bm_mode_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic none_sel;
    } bm_ctrl_t;

    // Priority: chip select, then write strobe, then output gating.
    function automatic bm_mode_e bm_decode(bm_ctrl_t c);
        if (c.ce_n)
            return MD_DESEL;
        else if (!c.we_n)
            return MD_WRITE;
        else if (c.oe_n || c.none_sel)
            return MD_QUIET;
        else
            return MD_READ;
    endfunction

endpackage

// File: rtl/bmem_pin_sample.sv
module bmem_pin_sample #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic [LANES-1:0]        bs_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    supply_low,
    output logic                    s_ce_n,
    output logic                    s_we_n,
    output logic                    s_oe_n,
    output logic [LANES-1:0]        s_bs_n,
    output logic [ADDR_W-1:0]       s_addr,
    output logic [LANES*LANE_W-1:0] s_din,
    output logic                    s_low
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_ce_n <= 1'b1;
            s_we_n <= 1'b1;
            s_oe_n <= 1'b1;
            s_bs_n <= '1;
            s_addr <= '0;
            s_din  <= '0;
            s_low  <= 1'b0;
        end else begin
            s_ce_n <= ce_n;
            s_we_n <= we_n;
            s_oe_n <= oe_n;
            s_bs_n <= bs_n;
            s_addr <= addr;
            s_din  <= din;
            s_low  <= supply_low;
        end
    end

endmodule

// File: rtl/bmem_write_guard.sv
module bmem_write_guard #(
    parameter int RECOVER_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic s_low,
    output logic wr_ok
);

    localparam int CW = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(RECOVER_CYC);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst || s_low)
            hold_cnt <= RELOAD;
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    assign wr_ok = !s_low && (hold_cnt == '0);

endmodule

// File: rtl/bmem_lane_array.sv
module bmem_lane_array #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // No reset: contents model nonvolatile storage.
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end

endmodule

// File: rtl/bmem_lane_drive.sv
module bmem_lane_drive #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        rd_lane,
    input  logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES*LANE_W-1:0] dout,
    output logic [LANES-1:0]        dout_en
);

    for (genvar g = 0; g < LANES; g++) begin : g_drv
        always_ff @(posedge clk) begin
            if (rst) begin
                dout_en[g]                <= 1'b0;
                dout[g*LANE_W +: LANE_W] <= '0;
            end else begin
                dout_en[g]                <= rd_lane[g];
                dout[g*LANE_W +: LANE_W] <= rd_lane[g] ? rdata[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/bytemem_core.sv
module bytemem_core
    import bmem_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int LANE_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int RECOVER_CYC = 100000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic [LANES-1:0]        bs_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    supply_low,
    output logic [LANES*LANE_W-1:0] dout,
    output logic [LANES-1:0]        dout_en
);

    localparam int DW = LANES * LANE_W;

    logic              smp_ce_n, smp_we_n, smp_oe_n, smp_low;
    logic [LANES-1:0]  smp_bs_n;
    logic [ADDR_W-1:0] smp_addr;
    logic [DW-1:0]     smp_din;
    logic              wr_ok;
    bm_ctrl_t          ctrl;
    bm_mode_e          mode;
    logic [LANES-1:0]  lane_sel, wr_lane, rd_lane;
    logic [DW-1:0]     rdata;

    bmem_pin_sample #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_smp (
        .clk(clk), .rst(rst),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .bs_n(bs_n),
        .addr(addr), .din(din), .supply_low(supply_low),
        .s_ce_n(smp_ce_n), .s_we_n(smp_we_n), .s_oe_n(smp_oe_n),
        .s_bs_n(smp_bs_n), .s_addr(smp_addr), .s_din(smp_din), .s_low(smp_low)
    );

    bmem_write_guard #(.RECOVER_CYC(RECOVER_CYC)) u_grd (
        .clk(clk), .rst(rst), .s_low(smp_low), .wr_ok(wr_ok)
    );

    always_comb begin
        ctrl.ce_n     = smp_ce_n;
        ctrl.we_n     = smp_we_n;
        ctrl.oe_n     = smp_oe_n;
        ctrl.none_sel = &smp_bs_n;
        mode          = bm_decode(ctrl);
        lane_sel      = ~smp_bs_n;
        wr_lane       = (mode == MD_WRITE && wr_ok) ? lane_sel : '0;
        rd_lane       = (mode == MD_READ) ? lane_sel : '0;
    end

    bmem_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .wr_lane(wr_lane), .addr(smp_addr),
        .wdata(smp_din), .rdata(rdata)
    );

    bmem_lane_drive #(.LANES(LANES), .LANE_W(LANE_W)) u_drv (
        .clk(clk), .rst(rst), .rd_lane(rd_lane), .rdata(rdata),
        .dout(dout), .dout_en(dout_en)
    );

endmodule

// File: rtl/bytemem_chk.sv
module bytemem_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    s_ce_n,
    input logic                    s_we_n,
    input logic                    s_oe_n,
    input logic [LANES-1:0]        s_bs_n,
    input logic                    s_low,
    input logic                    wr_ok,
    input logic [LANES*LANE_W-1:0] dout,
    input logic [LANES-1:0]        dout_en
);

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        s_ce_n |=> (dout_en == '0)); // R1

    AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!s_ce_n && s_we_n && s_oe_n) |=> (dout_en == '0)); // R2

    AST_READ_LANES: assert property (@(posedge clk) disable iff (rst)
        (!s_ce_n && s_we_n && !s_oe_n) |=> (dout_en == ~$past(s_bs_n))); // R3

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!s_ce_n && !s_we_n) |=> (dout_en == '0)); // R5

    AST_LOW_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        s_low |-> !wr_ok); // R6

    AST_RECOVER_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(s_low) |-> !wr_ok); // R7

    for (genvar g = 0; g < LANES; g++) begin : g_idle
        AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !dout_en[g] |-> (dout[g*LANE_W +: LANE_W] == '0)); // R3
    end

endmodule

bind bytemem_core bytemem_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst(rst),
    .s_ce_n(smp_ce_n), .s_we_n(smp_we_n), .s_oe_n(smp_oe_n),
    .s_bs_n(smp_bs_n), .s_low(smp_low), .wr_ok(wr_ok),
    .dout(dout), .dout_en(dout_en)
);

// File: tb/sim_bytemem_core.sv
module sim_bytemem_core;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int ADDR_W = 8;
    localparam int RECOV  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
    logic [1:0]        bs_n = 2'b11;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       din = '0;
    logic [15:0]       dout;
    logic [1:0]        dout_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bytemem_core #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .RECOVER_CYC(RECOV)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .bs_n(bs_n),
        .addr(addr), .din(din), .supply_low(supply_low), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pins(logic c, logic w, logic o, logic [1:0] b, logic [7:0] a, logic [15:0] d);
        ce_n = c; we_n = w; oe_n = o; bs_n = b; addr = a; din = d;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        pins(1'b1, 1'b1, 1'b1, 2'b11, 8'h00, 16'h0000);
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pins(1'b1, 1'b1, 1'b1, 2'b11, 8'h00, 16'h0000);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9", "en in reset", 32'(dout_en), 32'h0);
        chk("R9", "dout in reset", 32'(dout), 32'h0);
        rst = 1'b0;
        repeat (RECOV + 4) @(posedge clk);
        @(negedge clk);
        chk("R9", "en after reset", 32'(dout_en), 32'h0);
    endtask

    task automatic do_write(logic [7:0] a, logic [1:0] b, logic [15:0] d, logic o);
        pins(1'b0, 1'b0, o, b, a, d);
        settle();
        chk("R5", "en during write", 32'(dout_en), 32'h0);
        idle();
    endtask

    task automatic do_read(string req, logic [7:0] a, logic [1:0] b,
                           logic [1:0] exp_en, logic [15:0] exp_d);
        pins(1'b0, 1'b1, 1'b0, b, a, 16'hFFFF);
        settle();
        chk(req, "read en", 32'(dout_en), 32'(exp_en));
        chk(req, "read data", 32'(dout), 32'(exp_d));
    endtask

    task automatic t_word_and_bytes();
        do_write(8'h05, 2'b00, 16'hA5C3, 1'b1);
        do_read("R4", 8'h05, 2'b00, 2'b11, 16'hA5C3);
        do_write(8'h05, 2'b10, 16'h1177, 1'b0);   // lower lane only, oe_n low
        do_read("R4", 8'h05, 2'b00, 2'b11, 16'hA577);
        do_write(8'h05, 2'b01, 16'h8866, 1'b1);   // upper lane only
        do_read("R4", 8'h05, 2'b00, 2'b11, 16'h8877);
        do_write(8'h05, 2'b11, 16'h0000, 1'b1);   // no lane selected
        do_read("R4", 8'h05, 2'b00, 2'b11, 16'h8877);
    endtask

    task automatic t_lane_reads();
        do_read("R3", 8'h05, 2'b10, 2'b01, 16'h0077);
        do_read("R3", 8'h05, 2'b01, 2'b10, 16'h8800);
    endtask

    task automatic t_disabled();
        pins(1'b0, 1'b1, 1'b1, 2'b00, 8'h05, 16'h0);
        settle();
        chk("R2", "oe high en", 32'(dout_en), 32'h0);
        chk("R2", "oe high data", 32'(dout), 32'h0);
        pins(1'b0, 1'b1, 1'b0, 2'b11, 8'h05, 16'h0);
        settle();
        chk("R2", "no select en", 32'(dout_en), 32'h0);
    endtask

    task automatic t_deselect();
        pins(1'b1, 1'b0, 1'b0, 2'b00, 8'h05, 16'hDEAD);
        settle();
        chk("R1", "deselect en", 32'(dout_en), 32'h0);
        chk("R1", "deselect data", 32'(dout), 32'h0);
        idle();
        do_read("R1", 8'h05, 2'b00, 2'b11, 16'h8877);
    endtask

    task automatic t_oe_late();
        pins(1'b0, 1'b0, 1'b1, 2'b00, 8'h09, 16'h1234);
        settle();
        oe_n = 1'b0;
        settle();
        chk("R5", "late oe en", 32'(dout_en), 32'h0);
        idle();
        do_read("R4", 8'h09, 2'b00, 2'b11, 16'h1234);
    endtask

    task automatic t_supply();
        supply_low = 1'b1;
        do_write(8'h05, 2'b00, 16'h5555, 1'b1);
        do_read("R6", 8'h05, 2'b00, 2'b11, 16'h8877);
        idle();
        supply_low = 1'b0;
        do_write(8'h05, 2'b00, 16'h6666, 1'b1);
        do_read("R7", 8'h05, 2'b00, 2'b11, 16'h8877);
        idle();
        repeat (RECOV + 4) @(posedge clk);
        @(negedge clk);
        do_write(8'h05, 2'b00, 16'h7777, 1'b1);
        do_read("R7", 8'h05, 2'b00, 2'b11, 16'h7777);
        idle();
    endtask

    task automatic t_persist();
        do_reset();
        do_read("R8", 8'h05, 2'b00, 2'b11, 16'h7777);
        do_read("R8", 8'h09, 2'b00, 2'b11, 16'h1234);
        idle();
    endtask

    task automatic t_latency();
        idle();
        pins(1'b0, 1'b1, 1'b0, 2'b00, 8'h09, 16'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "en after one edge", 32'(dout_en), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "en after two edges", 32'(dout_en), 32'h3);
        chk("R10", "data after two edges", 32'(dout), 32'h1234);
        idle();
    endtask

    initial begin
        do_reset();
        t_word_and_bytes();
        t_lane_reads();
        t_disabled();
        t_deselect();
        t_oe_late();
        t_supply();
        t_persist();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule